// File: doc/BRIEF.md
# Warp Context Switch Scheduler

This block holds the resident warps of one execution engine and picks which of them issues each cycle. The context of a warp is small: a program counter and one contiguous range of vector registers, given by a base index and a length. Moving from one warp to another changes only these three values at the datapath. There is no branch prediction and no out-of-order execution, so latency is hidden only by moving to another warp.

A launch request gives a start PC and a register demand. The demand is rounded up to whole allocation blocks and placed first-fit in a free map. If no free slot exists, or no contiguous free run is long enough, the launch is held back. In each cycle, one eligible warp is chosen round-robin. Its PC, register base and register length are presented together with a valid flag. The execution side returns the kind of the presented instruction in the same cycle. A warp may issue any number of loads in a row without stalling. It parks only on an explicit wait instruction issued while it still has loads outstanding. It becomes eligible again once completion tokens have returned all of those loads. When no warp can issue, the idle flag is raised.

Top module: `warp_sched`

## Requirements
- R1: After reset no warp is resident: `issue_valid_o`=0, `idle_o`=1 and `launch_ready_o`=1.
- R2: `launch_ready_o` is 1 exactly when both of these hold: a warp slot is free, and a contiguous run of ceil(`launch_nregs_i`/BLK_REGS) free blocks exists. A launch is taken when valid and ready are both high. With 64 registers and 8-register blocks, two launches of 25 registers fit and a third is held back.
- R3: A taken launch occupies the lowest free slot and the lowest-starting free run. The issue outputs show base = start block × BLK_REGS and length = block count × BLK_REGS.
- R4: A newly taken warp presents its launch PC. Each issue of that warp that is not an exit adds 1 to its PC (modulo 2^PC_W).
- R5: Each cycle, the eligible warp chosen is the first one found when scanning upward, with wrap-around, from the slot after the last warp that issued. After reset the last issuer counts as slot NUM_WARPS-1.
- R6: `issue_kind_i` encoding: 0 = ALU, 1 = load, 2 = wait, 3 = exit. A load issue adds 1 to the warp's outstanding count. A completion token on `done_warp_i` subtracts 1, and both can happen in one cycle. Loads never make a warp ineligible.
- R7: A wait issue parks the warp if its outstanding count after that cycle's updates is non-zero. Otherwise the warp stays eligible. A parked warp is never selected.
- R8: A parked warp is eligible again from the cycle after its outstanding count reaches zero.
- R9: `idle_o` is 1 and `issue_valid_o` is 0 in any cycle in which no resident warp is eligible.
- R10: An exit issue frees the warp's slot and its register blocks from the next cycle on. An exit is only issued with no loads outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| launch_valid_i | input | 1 | Launch request |
| launch_ready_o | output | 1 | Launch can be taken this cycle |
| launch_pc_i | input | PC_W | Start PC of the new warp |
| launch_nregs_i | input | RLEN_W | Registers requested, 1 to NUM_REGS |
| issue_valid_o | output | 1 | A warp is presented for issue |
| issue_warp_o | output | WID_W | Slot of the presented warp |
| issue_pc_o | output | PC_W | PC of the presented warp |
| issue_rbase_o | output | RIDX_W | First register of the presented warp |
| issue_rlen_o | output | RLEN_W | Register count of the presented warp |
| issue_kind_i | input | 2 | Kind of the presented instruction, same cycle |
| done_valid_i | input | 1 | Load completion token |
| done_warp_i | input | WID_W | Warp owning the completed load |
| idle_o | output | 1 | No warp can issue |

## Verification
The hardest state to reach is every resident warp parked at the same time while loads are still in flight, followed by wake-ups in an order that differs from the park order. The bench opens stall windows in which completion tokens are withheld and the instruction stream is biased toward loads and waits, so every warp parks and idle rises. Tokens then resume for random warps, and a cycle-level reference model follows the counts, the round-robin pointer and the free map across launches and exits.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  typedef enum logic [1:0] {
    KIND_ALU  = 2'd0,
    KIND_LOAD = 2'd1,
    KIND_WAIT = 2'd2,
    KIND_EXIT = 2'd3
  } kind_e;
endpackage

// File: rtl/warp_reg_alloc.sv
module warp_reg_alloc #(
  parameter int NUM_BLKS = 32,
  localparam int BW = $clog2(NUM_BLKS),
  localparam int LW = $clog2(NUM_BLKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] req_len_i,
  input  logic          alloc_en_i,
  input  logic          rel_en_i,
  input  logic [BW-1:0] rel_base_i,
  input  logic [LW-1:0] rel_len_i,
  output logic          fit_o,
  output logic [BW-1:0] base_o
);
  logic [NUM_BLKS-1:0] used_q, alloc_mask, rel_mask;

  function automatic logic [NUM_BLKS-1:0] span(input int b, input int l);
    logic [NUM_BLKS-1:0] m;
    for (int i = 0; i < NUM_BLKS; i++) m[i] = (i >= b) && (i < b + l);
    return m;
  endfunction

  // first fit: descending scan leaves the lowest start
  always_comb begin
    fit_o  = 1'b0;
    base_o = '0;
    for (int s = NUM_BLKS - 1; s >= 0; s--) begin
      if (req_len_i != '0 && s + int'(req_len_i) <= NUM_BLKS &&
          (used_q & span(s, int'(req_len_i))) == '0) begin
        fit_o  = 1'b1;
        base_o = BW'(s);
      end
    end
  end

  assign alloc_mask = alloc_en_i ? span(int'(base_o), int'(req_len_i)) : '0;
  assign rel_mask   = rel_en_i ? span(int'(rel_base_i), int'(rel_len_i)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) used_q <= '0;
    else         used_q <= (used_q & ~rel_mask) | alloc_mask;
  end

  AST_REL_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_en_i |-> (used_q & rel_mask) == rel_mask); // R10
  AST_ALLOC_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |=> (used_q & $past(alloc_mask)) == $past(alloc_mask)); // R2
endmodule

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig_i,
  input  logic [IW-1:0] last_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = N; k >= 1; k--) begin
      if (elig_i[(int'(last_i) + k) % N]) begin
        valid_o = 1'b1;
        idx_o   = IW'((int'(last_i) + k) % N);
      end
    end
  end
endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 256,
  parameter int BLK_REGS  = 8,
  parameter int PC_W      = 16,
  parameter int CNT_W     = 4,
  localparam int NUM_BLKS = NUM_REGS / BLK_REGS,
  localparam int WID_W    = $clog2(NUM_WARPS),
  localparam int RIDX_W   = $clog2(NUM_REGS),
  localparam int RLEN_W   = $clog2(NUM_REGS + 1),
  localparam int BW       = $clog2(NUM_BLKS),
  localparam int LW       = $clog2(NUM_BLKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_valid_i,
  output logic              launch_ready_o,
  input  logic [PC_W-1:0]   launch_pc_i,
  input  logic [RLEN_W-1:0] launch_nregs_i,
  output logic              issue_valid_o,
  output logic [WID_W-1:0]  issue_warp_o,
  output logic [PC_W-1:0]   issue_pc_o,
  output logic [RIDX_W-1:0] issue_rbase_o,
  output logic [RLEN_W-1:0] issue_rlen_o,
  input  logic [1:0]        issue_kind_i,
  input  logic              done_valid_i,
  input  logic [WID_W-1:0]  done_warp_i,
  output logic              idle_o
);
  logic [NUM_WARPS-1:0] vld_q, wait_q, elig;
  logic [PC_W-1:0]      pc_q  [NUM_WARPS];
  logic [BW-1:0]        bb_q  [NUM_WARPS];
  logic [LW-1:0]        bl_q  [NUM_WARPS];
  logic [CNT_W-1:0]     cnt_q [NUM_WARPS];
  logic [CNT_W-1:0]     cnt_n [NUM_WARPS];
  logic [WID_W-1:0]     last_q, free_idx;
  logic                 slot_ok, fit, launch_fire, exit_fire;
  logic [BW-1:0]        fit_base;
  logic [LW-1:0]        req_blks;
  logic [RLEN_W:0]      req_round;
  kind_e                kind;

  assign kind      = kind_e'(issue_kind_i);
  assign req_round = ({1'b0, launch_nregs_i} + (RLEN_W+1)'(BLK_REGS - 1)) / (RLEN_W+1)'(BLK_REGS);
  assign req_blks  = LW'(req_round);

  always_comb begin
    slot_ok  = 1'b0;
    free_idx = '0;
    for (int w = NUM_WARPS - 1; w >= 0; w--) begin
      if (!vld_q[w]) begin
        slot_ok  = 1'b1;
        free_idx = WID_W'(w);
      end
    end
  end

  assign launch_ready_o = slot_ok & fit;
  assign launch_fire    = launch_valid_i & launch_ready_o;
  assign exit_fire      = issue_valid_o && kind == KIND_EXIT;

  warp_reg_alloc #(.NUM_BLKS(NUM_BLKS)) u_alloc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_len_i  (req_blks),
    .alloc_en_i (launch_fire),
    .rel_en_i   (exit_fire),
    .rel_base_i (bb_q[issue_warp_o]),
    .rel_len_i  (bl_q[issue_warp_o]),
    .fit_o      (fit),
    .base_o     (fit_base)
  );

  warp_rr_pick #(.N(NUM_WARPS)) u_pick (
    .elig_i  (elig),
    .last_i  (last_q),
    .valid_o (issue_valid_o),
    .idx_o   (issue_warp_o)
  );

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic sel, inc, dec;
    assign sel     = issue_valid_o && issue_warp_o == WID_W'(w);
    assign inc     = sel && kind == KIND_LOAD;
    assign dec     = done_valid_i && done_warp_i == WID_W'(w);
    assign cnt_n[w] = cnt_q[w] + CNT_W'(inc) - CNT_W'(dec);
    // parked warp wakes as soon as its registered count is zero
    assign elig[w] = vld_q[w] && (!wait_q[w] || cnt_q[w] == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[w]  <= 1'b0;
        wait_q[w] <= 1'b0;
        pc_q[w]   <= '0;
        bb_q[w]   <= '0;
        bl_q[w]   <= '0;
        cnt_q[w]  <= '0;
      end else if (launch_fire && free_idx == WID_W'(w)) begin
        vld_q[w]  <= 1'b1;
        wait_q[w] <= 1'b0;
        pc_q[w]   <= launch_pc_i;
        bb_q[w]   <= fit_base;
        bl_q[w]   <= req_blks;
        cnt_q[w]  <= '0;
      end else begin
        cnt_q[w] <= cnt_n[w];
        if (sel) begin
          pc_q[w]   <= pc_q[w] + PC_W'(1);
          wait_q[w] <= kind == KIND_WAIT && cnt_n[w] != '0;
          if (kind == KIND_EXIT) vld_q[w] <= 1'b0;
        end
      end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec |-> cnt_q[w] != '0 || inc); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc && !dec |-> cnt_q[w] != '1); // R6
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            last_q <= WID_W'(NUM_WARPS - 1);
    else if (issue_valid_o) last_q <= issue_warp_o;
  end

  assign issue_pc_o    = pc_q[issue_warp_o];
  assign issue_rbase_o = RIDX_W'(int'(bb_q[issue_warp_o]) * BLK_REGS);
  assign issue_rlen_o  = RLEN_W'(int'(bl_q[issue_warp_o]) * BLK_REGS);
  assign idle_o        = ~issue_valid_o;

  AST_PICK_RESIDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> vld_q[issue_warp_o]); // R5
  AST_WAIT_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o && kind == KIND_WAIT && cnt_n[issue_warp_o] != '0
    |=> !(issue_valid_o && issue_warp_o == $past(issue_warp_o))); // R7
  AST_EXIT_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_fire |-> cnt_q[issue_warp_o] == '0); // R10
  AST_IDLE_NO_ELIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> elig == '0); // R9
endmodule

// File: tb/warp_sched_bench.sv
module warp_sched_bench;
  localparam int NW = 4, NR = 64, BR = 8, NB = NR / BR;

  logic       clk = 0, rst_n = 0;
  logic       launch_valid = 0, launch_ready;
  logic [15:0] launch_pc = 0;
  logic [6:0] launch_nregs = 1;
  logic       issue_valid, idle;
  logic [1:0] issue_warp, issue_kind = 0;
  logic [15:0] issue_pc;
  logic [5:0] issue_rbase;
  logic [6:0] issue_rlen;
  logic       done_valid = 0;
  logic [1:0] done_warp = 0;

  int n_chk = 0, n_fail = 0, saw_idle = 0;
  bit finished = 0;

  int m_vld[NW], m_wait[NW], m_pc[NW], m_bb[NW], m_bl[NW], m_cnt[NW];
  int m_used[NB];
  int m_last;

  always #5 clk = ~clk;

  warp_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .BLK_REGS(BR), .PC_W(16), .CNT_W(4)) u_warp_sched (
    .clk_i(clk), .rst_ni(rst_n),
    .launch_valid_i(launch_valid), .launch_ready_o(launch_ready),
    .launch_pc_i(launch_pc), .launch_nregs_i(launch_nregs),
    .issue_valid_o(issue_valid), .issue_warp_o(issue_warp), .issue_pc_o(issue_pc),
    .issue_rbase_o(issue_rbase), .issue_rlen_o(issue_rlen), .issue_kind_i(issue_kind),
    .done_valid_i(done_valid), .done_warp_i(done_warp), .idle_o(idle)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit m_elig(int w);
    return m_vld[w] != 0 && (m_wait[w] == 0 || m_cnt[w] == 0);
  endfunction

  function automatic int m_pick();  // -1 when none (R5)
    for (int k = 1; k <= NW; k++) if (m_elig((m_last + k) % NW)) return (m_last + k) % NW;
    return -1;
  endfunction

  function automatic int m_fit(int len);  // -1 when none (R3)
    for (int s = 0; s + len <= NB; s++) begin
      bit ok = 1;
      for (int i = s; i < s + len; i++) if (m_used[i] != 0) ok = 0;
      if (ok) return s;
    end
    return -1;
  endfunction

  function automatic int m_slot();
    for (int w = 0; w < NW; w++) if (m_vld[w] == 0) return w;
    return -1;
  endfunction

  // policy: 0 mixed, 1 ALU only, 2 load/wait heavy
  task automatic step(bit lv, int nregs, bit dn_en, int policy);
    int w, blks, slot, base, ready, kind, dw;
    bit dv;
    @(negedge clk);
    launch_valid = lv;
    launch_nregs = 7'(nregs);
    launch_pc    = 16'($urandom);
    dv = 0; dw = 0;
    if (dn_en && ($urandom % 2) == 0) begin
      int off = $urandom % NW;
      for (int k = 0; k < NW; k++)
        if (!dv && m_cnt[(off + k) % NW] > 0) begin dv = 1; dw = (off + k) % NW; end
    end
    done_valid = dv;
    done_warp  = 2'(dw);
    #1;
    blks  = (nregs + BR - 1) / BR;
    slot  = m_slot();
    base  = m_fit(blks);
    ready = (slot >= 0 && base >= 0) ? 1 : 0;
    w     = m_pick();
    check("R2 R10 launch_ready", int'(launch_ready), ready);
    check("R8 issue_valid", int'(issue_valid), w >= 0 ? 1 : 0);
    check("R9 idle", int'(idle), w < 0 ? 1 : 0);
    if (w < 0 && m_vld[0] + m_vld[1] + m_vld[2] + m_vld[3] > 0) saw_idle++;
    kind = 0;
    if (w >= 0) begin
      int r = $urandom % 16;
      check("R5 R6 R7 issue_warp", int'(issue_warp), w);
      check("R4 issue_pc", int'(issue_pc), m_pc[w]);
      check("R3 issue_rbase", int'(issue_rbase), m_bb[w] * BR);
      check("R3 issue_rlen", int'(issue_rlen), m_bl[w] * BR);
      if (policy == 1) kind = 0;
      else if (policy == 2) kind = (r < 9) ? 1 : (r < 14 ? 2 : 0);
      else kind = (r < 5) ? 1 : (r < 8 ? 2 : (r == 8 ? 3 : 0));
      if (kind == 1 && m_cnt[w] >= 14) kind = 2;
      if (kind == 3 && m_cnt[w] != 0) kind = 0;  // R10 exit only when drained
    end
    issue_kind = 2'(kind);
    @(posedge clk);
    #1;
    // reference update with pre-edge state
    if (dv) m_cnt[dw]--;
    if (w >= 0) begin
      if (kind == 1) m_cnt[w]++;
      m_pc[w]   = (m_pc[w] + 1) & 16'hFFFF;
      m_wait[w] = (kind == 2 && m_cnt[w] != 0) ? 1 : 0;
      if (kind == 3) begin
        m_vld[w] = 0;
        for (int i = m_bb[w]; i < m_bb[w] + m_bl[w]; i++) m_used[i] = 0;
      end
      m_last = w;
    end
    if (lv && ready != 0) begin
      m_vld[slot] = 1; m_wait[slot] = 0; m_cnt[slot] = 0;
      m_pc[slot] = int'(launch_pc); m_bb[slot] = base; m_bl[slot] = blks;
      for (int i = base; i < base + blks; i++) m_used[i] = 1;
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) begin m_vld[i] = 0; m_wait[i] = 0; m_pc[i] = 0; m_bb[i] = 0; m_bl[i] = 0; m_cnt[i] = 0; end
    for (int i = 0; i < NB; i++) m_used[i] = 0;
    m_last = NW - 1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 launch_ready", int'(launch_ready), 1);
    check("R1 issue_valid", int'(issue_valid), 0);
    check("R1 idle", int'(idle), 1);
    rst_n = 1;
    // register budget: two 25-register warps fill 64 regs in 8-reg blocks
    step(1, 25, 0, 1);
    step(1, 25, 0, 1);
    #2;
    check("R2 budget full", int'(launch_ready), 0);
    step(1, 25, 0, 1);
    for (int c = 0; c < 20; c++) step(0, 1, 0, 1);
    for (int blk = 0; blk < 12; blk++) begin
      for (int c = 0; c < 300; c++)
        step(($urandom % 4) == 0, 1 + $urandom % NR, 1, 0);
      // stall window: tokens withheld until every warp parks
      for (int c = 0; c < 60; c++) step(($urandom % 8) == 0, 1 + $urandom % 24, 0, 2);
      for (int c = 0; c < 40; c++) step(0, 1, 1, 1);
    end
    check("R9 all parked reached", saw_idle > 0 ? 1 : 0, 1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule